// File: doc/BRIEF.md
# Reciprocal-Multiply Signed Integer Divider

This block divides one 32-bit two's-complement integer by another and returns the quotient truncated toward zero. It has no shift-subtract loop. It first removes the operand signs. It then takes an estimate of the divisor's reciprocal, scaled by 2^32, that is deliberately rounded low. Newton-style refinement passes sharpen that estimate using the high and low halves of 32x32 products. The block multiplies the dividend by the refined reciprocal to get a trial quotient. Two compare-and-increment steps correct that quotient, and the sign is then put back.

Each 32x32 product comes from one shared multiplier, driven one step per cycle by a small sequencer, so the time from accept to result never changes. The seed comes from a leading-zero normalization of the divisor magnitude and a computed table of mantissa reciprocals, shifted back into 32 bits. Operands enter through a valid/ready handshake and the quotient leaves through another. A divide by zero returns all ones and raises a flag that stays set until reset.

Top module: `rcp_sdiv`

## Requirements
- R1: Each operand's magnitude is formed as (x + m) XOR m, where m is the operand's sign bit copied across all 32 bits. The result is negative exactly when the operand signs differ; the sign is applied as (q XOR m) - m, where m is that result-sign mask. This covers -2^31 (0x80000000), whose magnitude is 2^31.
- R2: For every nonzero divisor, out_quotient equals the dividend divided by the divisor, truncated toward zero. The one exception is covered by R3.
- R3: 0x80000000 divided by 0xFFFFFFFF (-1) returns 0x80000000 and does not set div_by_zero.
- R4: A zero divisor returns 0xFFFFFFFF and sets div_by_zero when the result is presented. The flag then stays 1 through later operations until reset.
- R5: out_valid rises exactly LATENCY = 5 + 2*REFINE_STEPS clock edges after the edge that accepts the operands. With the default of 2 refinement steps, that is 9 edges.
- R6: in_ready is high only when no operation is in flight and no result is pending. While out_valid is high and out_ready is low, out_valid stays high and out_quotient holds its value. Each accepted operand pair produces exactly one result.
- R7: The reciprocal estimate never exceeds 2^32/d. At every refinement step, d*r <= 2^32, where d is the divisor magnitude and r is the current estimate.
- R8: The trial quotient never exceeds the true quotient (q*d <= n). After the first correction, the partial remainder is below 2*d, so the second +1 correction is always enough.
- R9: While rst_n is low at a clock edge, the block clears itself. It then shows out_valid = 0, in_ready = 1 and div_by_zero = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operand pair is offered |
| in_ready | output | 1 | Block can accept an operand pair |
| in_dividend | input | 32 | Signed dividend |
| in_divisor | input | 32 | Signed divisor |
| out_valid | output | 1 | Quotient is presented |
| out_ready | input | 1 | Consumer takes the quotient |
| out_quotient | output | 32 | Signed quotient, truncated toward zero |
| div_by_zero | output | 1 | Sticky flag for a zero divisor |

## Verification
Several properties are checked on every cycle for whatever operands arrive:
- the reciprocal estimate stays at or below the true reciprocal at each refinement step;
- the trial quotient never overshoots;
- the partial remainder after the first correction is below twice the divisor;
- the fixed latency, result holding under back-pressure, exclusive ready/valid and the stickiness of the zero flag.

Only the bench scenarios can show the actual quotient values. These scenarios cover sign combinations, the extreme values 0x7FFFFFFF and 0x80000000, dividends smaller than the divisor, the wrapping -2^31 / -1 case, the all-ones zero-divisor result, and reset clearing the sticky flag.

// File: rtl/rcpdiv_pkg.sv
`timescale 1ns/1ps
// Package: shared types for the reciprocal-multiply divider.
// Assumes: a single sequencer walks these states in declaration order,
// with the refine pair (ST_ERR, ST_STEP) repeated REFINE_STEPS times.
package rcpdiv_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,   // waiting for an operand pair
        ST_SEED,   // load the table-based reciprocal estimate
        ST_ERR,    // error term e = 0 - low(d * r)
        ST_STEP,   // r = r + high(r * e)
        ST_TRIAL,  // q = high(n * r)
        ST_PREM,   // rem = n - low(q * d)
        ST_FIX1,   // first compare-and-increment, remainder updated
        ST_FIX2,   // second compare-and-increment, sign restored
        ST_DONE    // result presented
    } rd_state_e;

endpackage

// File: rtl/rcpdiv_unsign.sv
`timescale 1ns/1ps
// Module: rcpdiv_unsign
// Strips the sign of a two's-complement value: the mask is the sign bit
// copied across the word, and the magnitude is (x + mask) ^ mask.
// Assumes: the most negative value maps to 2^(W-1), read as unsigned.
module rcpdiv_unsign #(
    parameter int W = 32
) (
    input  logic [W-1:0] val_i,
    output logic [W-1:0] mag_o,
    output logic         neg_o
);

    logic [W-1:0] smask;

    // Sign mask: all ones for a negative input, zero otherwise.
    assign smask = {W{val_i[W-1]}};

    // Magnitude by add-then-invert with the mask.
    assign mag_o = (val_i + smask) ^ smask;

    // Sign bit passed on for the result-sign XOR.
    assign neg_o = val_i[W-1];

endmodule

// File: rtl/rcpdiv_seed.sv
`timescale 1ns/1ps
// Module: rcpdiv_seed
// Produces a low-rounded estimate of 2^W / d for an unsigned magnitude d.
// d is left-normalized. The K bits after the leading one index a table of
// floor(2^(W+K) / (2^K + i + 1)), which is the reciprocal at the top of
// each interval and therefore never above the true value. The entry is
// then shifted right by (W-1-lz).
// Assumes: d <= 2^(W-1) for nonzero d, so the result is >= 1. For d = 0
// the output is all ones (the caller overrides the result).
module rcpdiv_seed #(
    parameter int W = 32,
    parameter int K = 8
) (
    input  logic [W-1:0] dmag_i,
    output logic [W-1:0] seed_o
);

    localparam int ENTRIES = 1 << K;
    localparam int LZW     = $clog2(W) + 1;

    logic [W-1:0]   lut [ENTRIES];
    logic [LZW-1:0] lz;
    logic [LZW-1:0] sh;
    logic [W-1:0]   norm;
    logic [K-1:0]   idx;
    logic [W-1:0]   ytab;

    // Reciprocal table, computed at elaboration from the interval tops.
    for (genvar i = 0; i < ENTRIES; i++) begin : g_lut
        localparam logic [W+K:0] NUM = {1'b1, {(W+K){1'b0}}};
        localparam logic [W+K:0] DEN = (W+K+1)'(ENTRIES + i + 1);
        localparam logic [W+K:0] QV  = NUM / DEN;
        assign lut[i] = QV[W-1:0];
    end

    // Leading-zero count: the highest set bit wins; W when d is zero.
    always_comb begin
        lz = LZW'(W);
        for (int b = 0; b < W; b++) begin
            if (dmag_i[b]) lz = LZW'(W - 1 - b);
        end
    end

    // Normalize, index the table and denormalize back to W bits.
    always_comb begin
        norm   = dmag_i << lz;
        idx    = norm[W-2 -: K];
        ytab   = lut[idx];
        sh     = LZW'(W - 1) - lz;
        seed_o = (dmag_i == '0) ? '1 : (ytab >> sh);
    end

endmodule

// File: rtl/rcpdiv_mul.sv
`timescale 1ns/1ps
// Module: rcpdiv_mul
// One unsigned WxW multiplier giving the full 2W-bit product. The
// sequencer takes the high or low half as each step needs.
// Assumes: both operands are unsigned.
module rcpdiv_mul #(
    parameter int W = 32
) (
    input  logic [W-1:0]   a_i,
    input  logic [W-1:0]   b_i,
    output logic [2*W-1:0] p_o
);

    // Full-width product of zero-extended operands.
    always_comb begin
        p_o = {{W{1'b0}}, a_i} * {{W{1'b0}}, b_i};
    end

endmodule

// File: rtl/rcp_sdiv.sv
`timescale 1ns/1ps
// Module: rcp_sdiv
// Signed W-bit divider built on reciprocal multiplication.
// - Operands enter on a valid/ready handshake; the quotient leaves on another.
// - Signs are stripped, the divisor magnitude's reciprocal is seeded low
//   and refined REFINE_STEPS times.
// - A trial quotient is formed, corrected twice by +1 and re-signed.
// - All products share one multiplier, so latency is fixed at
//   5 + 2*REFINE_STEPS cycles.
// Assumes: W = 32, SEED_BITS >= 8 and REFINE_STEPS >= 2, which keeps the
// trial quotient within two of the truth. A zero divisor gives all ones
// and sets a sticky flag.
module rcp_sdiv
    import rcpdiv_pkg::*;
#(
    parameter int W            = 32,
    parameter int SEED_BITS    = 8,
    parameter int REFINE_STEPS = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] in_dividend,
    input  logic [W-1:0] in_divisor,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] out_quotient,
    output logic         div_by_zero
);

    localparam int LATENCY = 5 + 2 * REFINE_STEPS;
    localparam int CW      = $clog2(LATENCY + 1) + 1;
    localparam int SW      = $clog2(REFINE_STEPS) + 1;
    localparam logic [2*W-1:0] TWO_W = {{(W-1){1'b0}}, 1'b1, {W{1'b0}}};

    rd_state_e      st;
    logic [W-1:0]   nmag, dmag;
    logic           qneg, dz;
    logic [W-1:0]   r, e, q, rem, res;
    logic [SW-1:0]  stepc;
    logic [CW-1:0]  cyc;
    logic           sticky;

    logic [W-1:0]   n_in_mag, d_in_mag;
    logic           n_in_neg, d_in_neg;
    logic [W-1:0]   seed;
    logic [W-1:0]   mul_a, mul_b;
    logic [2*W-1:0] prod;
    logic [W-1:0]   q_fin, smask;
    logic           accept;

    // Sign stripping of both incoming operands.
    rcpdiv_unsign #(.W(W)) u_un_n (
        .val_i (in_dividend),
        .mag_o (n_in_mag),
        .neg_o (n_in_neg)
    );
    rcpdiv_unsign #(.W(W)) u_un_d (
        .val_i (in_divisor),
        .mag_o (d_in_mag),
        .neg_o (d_in_neg)
    );

    // Low-rounded reciprocal seed of the stored divisor magnitude.
    rcpdiv_seed #(.W(W), .K(SEED_BITS)) u_seed (
        .dmag_i (dmag),
        .seed_o (seed)
    );

    // Shared multiplier.
    rcpdiv_mul #(.W(W)) u_mul (
        .a_i (mul_a),
        .b_i (mul_b),
        .p_o (prod)
    );

    // Handshake outputs follow the sequencer state.
    assign in_ready     = (st == ST_IDLE);
    assign out_valid    = (st == ST_DONE);
    assign out_quotient = res;
    assign div_by_zero  = sticky;
    assign accept       = in_valid && in_ready;

    // Multiplier operand selection for each sequencer step.
    always_comb begin
        mul_a = '0;
        mul_b = '0;
        case (st)
            ST_ERR:   begin mul_a = dmag; mul_b = r;    end
            ST_STEP:  begin mul_a = r;    mul_b = e;    end
            ST_TRIAL: begin mul_a = nmag; mul_b = r;    end
            ST_PREM:  begin mul_a = q;    mul_b = dmag; end
            default:  begin mul_a = '0;   mul_b = '0;   end
        endcase
    end

    // Second correction and sign restore, applied at ST_FIX2.
    always_comb begin
        q_fin = q + ((rem >= dmag) ? W'(1) : W'(0));
        smask = {W{qneg}};
    end

    // Sequencer and datapath registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= ST_IDLE;
            nmag   <= '0;
            dmag   <= '0;
            qneg   <= 1'b0;
            dz     <= 1'b0;
            r      <= '0;
            e      <= '0;
            q      <= '0;
            rem    <= '0;
            res    <= '0;
            stepc  <= '0;
            sticky <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (in_valid) begin
                        nmag  <= n_in_mag;
                        dmag  <= d_in_mag;
                        qneg  <= n_in_neg ^ d_in_neg;
                        dz    <= (in_divisor == '0);
                        stepc <= '0;
                        st    <= ST_SEED;
                    end
                end
                ST_SEED: begin
                    r  <= seed;
                    st <= ST_ERR;
                end
                ST_ERR: begin
                    e  <= '0 - prod[W-1:0];
                    st <= ST_STEP;
                end
                ST_STEP: begin
                    r <= r + prod[2*W-1:W];
                    if (stepc == SW'(REFINE_STEPS - 1)) begin
                        st <= ST_TRIAL;
                    end else begin
                        stepc <= stepc + SW'(1);
                        st    <= ST_ERR;
                    end
                end
                ST_TRIAL: begin
                    q  <= prod[2*W-1:W];
                    st <= ST_PREM;
                end
                ST_PREM: begin
                    rem <= nmag - prod[W-1:0];
                    st  <= ST_FIX1;
                end
                ST_FIX1: begin
                    if (rem >= dmag) begin
                        q   <= q + W'(1);
                        rem <= rem - dmag;
                    end
                    st <= ST_FIX2;
                end
                ST_FIX2: begin
                    res <= dz ? '1 : ((q_fin ^ smask) - smask);
                    if (dz) sticky <= 1'b1;
                    st <= ST_DONE;
                end
                ST_DONE: begin
                    if (out_ready) st <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Cycle counter since accept, used only by the latency assertion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc <= '0;
        end else if (accept) begin
            cyc <= '0;
        end else if (st != ST_IDLE && st != ST_DONE) begin
            cyc <= cyc + CW'(1);
        end
    end

    // R7: the estimate is at or below the true reciprocal before each step.
    a_r7_underestimate: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ERR && !dz) |-> (prod <= TWO_W));

    // R8: the trial quotient never overshoots, so q*d fits under n.
    a_r8_no_overshoot: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PREM && !dz) |-> (prod <= {{W{1'b0}}, nmag}));

    // R8: after one correction the remainder is below twice the divisor.
    a_r8_two_fixes: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_FIX2 && !dz) |-> ({1'b0, rem} < {dmag, 1'b0}));

    // R5: the result appears a fixed number of cycles after accept.
    a_r5_latency: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> (cyc == CW'(LATENCY)));

    // R6: a stalled result stays valid and unchanged.
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_quotient)));

    // R6: no new accept while a result is pending.
    a_r6_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_ready && out_valid));

    // R4: the zero-divisor flag never clears without reset.
    a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        div_by_zero |=> div_by_zero);

endmodule

// File: tb/test_rcp_sdiv.sv
`timescale 1ns/1ps
// Bench for rcp_sdiv. A vector table first, then directed corner cases,
// then random operands checked against the language's signed division.
module test_rcp_sdiv;

    localparam int EXP_LAT = 9;  // 5 + 2 * default refine steps
    localparam int NVEC    = 18;
    // {dividend, divisor, expected quotient}
    localparam logic [95:0] VECS [NVEC] = '{
        {32'd100,        32'd7,          32'd14},
        {32'hFFFFFF9C,   32'd7,          32'hFFFFFFF2},
        {32'd100,        32'hFFFFFFF9,   32'hFFFFFFF2},
        {32'hFFFFFF9C,   32'hFFFFFFF9,   32'd14},
        {32'h7FFFFFFF,   32'd1,          32'h7FFFFFFF},
        {32'h7FFFFFFF,   32'h7FFFFFFF,   32'd1},
        {32'h80000000,   32'h80000000,   32'd1},
        {32'h80000000,   32'd2,          32'hC0000000},
        {32'd5,          32'd9,          32'd0},
        {32'h7FFFFFFF,   32'h80000000,   32'd0},
        {32'h80000000,   32'h7FFFFFFF,   32'hFFFFFFFF},
        {32'h7FFFFFFF,   32'd3,          32'h2AAAAAAA},
        {32'd1000000,    32'd1000,       32'd1000},
        {32'hFFFFFFFF,   32'd1,          32'hFFFFFFFF},
        {32'h40000000,   32'h00010000,   32'h00004000},
        {32'h7FFFFFFF,   32'h00010000,   32'h00007FFF},
        {32'h12345678,   32'h00001000,   32'h00012345},
        {32'd0,          32'hFFFFFFFB,   32'd0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_dividend = '0;
    logic [31:0] in_divisor = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [31:0] out_quotient;
    logic        div_by_zero;

    int tests = 0;
    int fails = 0;

    rcp_sdiv i_rcp_sdiv (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (in_valid),
        .in_ready     (in_ready),
        .in_dividend  (in_dividend),
        .in_divisor   (in_divisor),
        .out_valid    (out_valid),
        .out_ready    (out_ready),
        .out_quotient (out_quotient),
        .div_by_zero  (div_by_zero)
    );

    always #2.5 clk = ~clk;

    // Record one check.
    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Reference quotient written from the requirements.
    function automatic logic [31:0] ref_div(input logic [31:0] a, input logic [31:0] b);
        if (b == 32'd0) return 32'hFFFFFFFF;
        if (a == 32'h80000000 && b == 32'hFFFFFFFF) return 32'h80000000;
        return $signed(a) / $signed(b);
    endfunction

    // Run one division; optionally stall the consumer to test holding.
    task automatic do_div(input logic [31:0] a, input logic [31:0] b,
                          input logic [31:0] exp, input string req, input bit hold);
        int lat;
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_dividend = a;
        in_divisor  = b;
        in_valid    = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        lat = 1;
        while (!out_valid && lat < 100) begin
            @(negedge clk);
            lat++;
        end
        chk(lat == EXP_LAT + 1, "R5 latency", 32'(lat - 1), 32'(EXP_LAT));
        chk(out_quotient == exp, req, out_quotient, exp);
        if (hold) begin
            repeat (3) @(negedge clk);
            chk(out_valid && out_quotient == exp, "R6 hold", out_quotient, exp);
        end
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        chk(!out_valid && in_ready, "R6 release", {30'd0, out_valid, in_ready}, 32'd1);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R5 watchdog expired actual=%0d expected=%0d", 150000, 0);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [31:0] a, b;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state at the ports.
        chk(!out_valid && in_ready && !div_by_zero, "R9 reset state",
            {29'd0, out_valid, in_ready, div_by_zero}, 32'd2);

        // R1/R2: table walk, with stalls on every third entry (R6).
        for (int i = 0; i < NVEC; i++) begin
            do_div(VECS[i][95:64], VECS[i][63:32], VECS[i][31:0], "R1/R2 table", (i % 3) == 0);
        end

        // R3: most negative over minus one wraps, no flag.
        do_div(32'h80000000, 32'hFFFFFFFF, 32'h80000000, "R3 wrap", 1'b0);
        chk(!div_by_zero, "R3 no flag", {31'd0, div_by_zero}, 32'd0);

        // R1: powers of two in both signs, and +-1 divisors.
        for (int s = 0; s < 31; s++) begin
            do_div(32'h7FFFFFFF, 32'd1 << s, ref_div(32'h7FFFFFFF, 32'd1 << s), "R1/R2 pow2", 1'b0);
            do_div(32'h80000000, -(32'd1 << s), ref_div(32'h80000000, -(32'd1 << s)), "R1/R2 neg pow2", 1'b0);
        end
        do_div(32'd12345, 32'hFFFFFFFF, 32'hFFFFCFC7, "R1 minus one", 1'b0);

        // R4: zero divisor returns all ones and raises the flag.
        do_div(32'd77, 32'd0, 32'hFFFFFFFF, "R4 zero divisor", 1'b1);
        chk(div_by_zero, "R4 flag set", {31'd0, div_by_zero}, 32'd1);
        do_div(32'd50, 32'd5, 32'd10, "R2 after zero", 1'b0);
        chk(div_by_zero, "R4 flag sticky", {31'd0, div_by_zero}, 32'd1);

        // R9: reset clears the sticky flag.
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!div_by_zero && in_ready && !out_valid, "R9 reset clears flag",
            {29'd0, out_valid, in_ready, div_by_zero}, 32'd2);

        // R2/R7/R8: random operands, divisor widths varied by shifting.
        for (int k = 0; k < 600; k++) begin
            a = $urandom;
            b = $urandom >> ($urandom % 32);
            if (($urandom % 2) == 1) b = -b;
            if (b == 32'd0) b = 32'd3;
            if ((k % 5) == 0) a = a >> ($urandom % 32);
            do_div(a, b, ref_div(a, b), "R2/R7/R8 random", 1'b0);
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule